// File: doc/BRIEF.md
# Programmed I/O Peripheral Controller

This block is the device-side controller that sits on a shared, single-word programmed I/O bus. It watches a 10-bit address made of a device number and a function code. It acts on control pulses from the processor and answers condition tests on a shared reply line. It holds a 16-bit word buffer and four flags: busy, ready, interrupt mask and transfer direction.

Toward the attached device, the block accepts a newly arrived input word together with its arrival pulse. It presents the buffered output word, and it accepts a pulse that says that word has been taken. An interrupt request is raised while the device is ready and its mask is set. The device number, the data bit used for the mask and the function-code meanings are parameters.

Top module: `pio_dev_ctrl`

## Requirements
- R1: `bus_addr[5:0]` is the device number and `bus_addr[9:6]` the function code. A command, transfer, test or strobe whose device number differs from `DEV_ID` (default 6'o12) has no effect and gets no reply.
- R2: A control command with function 5 sets busy and ready and selects output mode (`dev_in_mode`=0). Function 4 sets busy, clears ready and selects input mode (`dev_in_mode`=1). Both are visible after the next clock edge.
- R3: A control command with function 3 clears busy and leaves ready, mask and buffer unchanged.
- R4: While `test_en` is high and the device is addressed, function 0 drives `reply` with ready and function 1 drives it with busy, in the same cycle. Any other function except 2 gives no reply.
- R5: The interrupt test (function 2) is inverted: `reply` is high when the device is not requesting an interrupt, and low when it is.
- R6: During an addressed input read (`read_en`), `in_bus` carries the buffer and `reply` is high only while ready. Otherwise `in_bus` is all zero.
- R7: An addressed reset-ready pulse clears ready. In input mode it also clears the buffer, and in output mode the buffer is kept.
- R8: An addressed output strobe while ready loads `out_bus` into the buffer. `dev_word_taken` in output mode while busy sets ready again.
- R9: `dev_word_arrived` in input mode while busy loads `dev_word_in` into the buffer and sets ready.
- R10: `mask_set` with the full address equal to 10'o020 copies `out_bus[MASK_BIT]` (default bit 5, bit 0 is the LSB) into the mask. A mask-set strobe with any other address leaves the mask unchanged.
- R11: `irq` is high exactly when ready and mask are both set.
- R12: `mstr_clr` or `pwr_norm` clears busy, ready and mask at the next edge, taking precedence over every other event. Buffer and direction are kept.
- R13: During an addressed output write (`write_en`), `reply` is high only while ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 10 | Function code [9:6], device number [5:0] |
| ctl_cmd | input | 1 | Control command pulse |
| test_en | input | 1 | Condition test cycle in progress |
| read_en | input | 1 | Input read cycle in progress |
| write_en | input | 1 | Output write cycle in progress |
| out_strobe | input | 1 | Output data strobe |
| rdy_reset | input | 1 | Reset-ready pulse |
| mask_set | input | 1 | Global mask-set pulse |
| out_bus | input | 16 | Processor output data bus |
| mstr_clr | input | 1 | Master clear level |
| pwr_norm | input | 1 | Power-on normalize pulse |
| dev_word_in | input | 16 | Word from the device |
| dev_word_arrived | input | 1 | Device has deposited a word |
| dev_word_taken | input | 1 | Device has taken the output word |
| in_bus | output | 16 | Processor input data bus contribution, zero when idle |
| reply | output | 1 | Shared reply line |
| irq | output | 1 | Interrupt request |
| dev_word_out | output | 16 | Buffered word presented to the device |
| dev_busy | output | 1 | Busy flag |
| dev_in_mode | output | 1 | 1 in input mode, 0 in output mode |

## Verification
`reply`, `in_bus` and `irq` are combinational from the stored flags and the current bus inputs, so they are due in the same cycle as the stimulus. Every flag and buffer change is due one clock edge after the pulse that causes it. The bench applies each stimulus on the falling edge and compares all outputs against a behavioural model 2 ns later. It advances the model on the rising edge, so each state change is seen at the first falling edge after the edge that should have produced it. Ready and mask changes are observed through the test replies and `irq`, because neither has a port of its own.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int DEV_W  = 6;
  localparam int FN_W   = 4;
  localparam int ADDR_W = DEV_W + FN_W;

  typedef logic [FN_W-1:0] fn_t;

  typedef struct packed {
    logic busy;
    logic ready;
    logic mask;
    logic dir_in;
  } dev_flags_t;
endpackage

// File: rtl/pio_addr_dec.sv
module pio_addr_dec #(
  parameter logic [pio_pkg::DEV_W-1:0]  DEV_ID    = 6'o12,
  parameter logic [pio_pkg::ADDR_W-1:0] MASK_CODE = 10'o020
) (
  input  logic [pio_pkg::ADDR_W-1:0] addr,
  output logic                       dev_hit,
  output logic                       mask_hit,
  output pio_pkg::fn_t               fn
);
  localparam int DW = pio_pkg::DEV_W;

  always_comb begin
    dev_hit  = (addr[DW-1:0] == DEV_ID);
    mask_hit = (addr == MASK_CODE);
    fn       = addr[pio_pkg::ADDR_W-1:DW];
  end
endmodule

// File: rtl/pio_dev_state.sv
module pio_dev_state #(
  parameter int           DATA_W    = 16,
  parameter int           MASK_BIT  = 5,
  parameter pio_pkg::fn_t FN_STOP   = 4'd3,
  parameter pio_pkg::fn_t FN_GO_IN  = 4'd4,
  parameter pio_pkg::fn_t FN_GO_OUT = 4'd5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                ocp_hit,
  input  logic                rrl_hit,
  input  logic                otp_hit,
  input  logic                smk_hit,
  input  pio_pkg::fn_t        fn,
  input  logic [DATA_W-1:0]   out_bus,
  input  logic [DATA_W-1:0]   dev_word_in,
  input  logic                dev_arrived,
  input  logic                dev_taken,
  output pio_pkg::dev_flags_t flags,
  output logic [DATA_W-1:0]   buf_q
);
  pio_pkg::dev_flags_t flags_nxt;
  logic [DATA_W-1:0]   buf_nxt;
  logic                buf_en;

  always_comb begin
    flags_nxt = flags;
    buf_nxt   = buf_q;
    buf_en    = 1'b0;
    if (clr) begin
      flags_nxt.busy  = 1'b0;
      flags_nxt.ready = 1'b0;
      flags_nxt.mask  = 1'b0;
    end else begin
      if (ocp_hit) begin
        if (fn == FN_STOP) begin
          flags_nxt.busy = 1'b0;
        end else if (fn == FN_GO_IN) begin
          flags_nxt.busy   = 1'b1;
          flags_nxt.ready  = 1'b0;
          flags_nxt.dir_in = 1'b1;
        end else if (fn == FN_GO_OUT) begin
          flags_nxt.busy   = 1'b1;
          flags_nxt.ready  = 1'b1;
          flags_nxt.dir_in = 1'b0;
        end
      end else if (rrl_hit) begin
        flags_nxt.ready = 1'b0;
        if (flags.dir_in) begin
          buf_en  = 1'b1;
          buf_nxt = '0;
        end
      end else if (otp_hit && flags.ready) begin
        buf_en  = 1'b1;
        buf_nxt = out_bus;
      end else if (dev_arrived && flags.busy && flags.dir_in) begin
        buf_en          = 1'b1;
        buf_nxt         = dev_word_in;
        flags_nxt.ready = 1'b1;
      end else if (dev_taken && flags.busy && !flags.dir_in) begin
        flags_nxt.ready = 1'b1;
      end
      if (smk_hit) flags_nxt.mask = out_bus[MASK_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      flags <= flags_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (buf_en) begin
      buf_q <= buf_nxt;
    end
  end

  a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!flags.busy && !flags.ready && !flags.mask));

  a_r2_go_out: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && ocp_hit && fn == FN_GO_OUT) |=> (flags.busy && flags.ready && !flags.dir_in));

  a_r2_go_in: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && ocp_hit && fn == FN_GO_IN) |=> (flags.busy && !flags.ready && flags.dir_in));

  a_r7_rrl_input: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ocp_hit && rrl_hit && flags.dir_in) |=> (!flags.ready && buf_q == '0));

  a_r7_rrl_output_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ocp_hit && rrl_hit && !flags.dir_in) |=> (!flags.ready && $stable(buf_q)));

  a_r10_mask_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && smk_hit) |=> (flags.mask == $past(out_bus[MASK_BIT])));
endmodule

// File: rtl/pio_reply.sv
module pio_reply #(
  parameter int           DATA_W  = 16,
  parameter pio_pkg::fn_t FN_RDY  = 4'd0,
  parameter pio_pkg::fn_t FN_BSY  = 4'd1,
  parameter pio_pkg::fn_t FN_INT  = 4'd2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dev_hit,
  input  pio_pkg::fn_t        fn,
  input  logic                test_en,
  input  logic                read_en,
  input  logic                write_en,
  input  pio_pkg::dev_flags_t flags,
  input  logic [DATA_W-1:0]   buf_q,
  output logic                reply,
  output logic [DATA_W-1:0]   in_bus,
  output logic                irq
);
  logic test_ans;

  always_comb begin
    irq = flags.ready && flags.mask;
    if (fn == FN_RDY)      test_ans = flags.ready;
    else if (fn == FN_BSY) test_ans = flags.busy;
    else if (fn == FN_INT) test_ans = !irq;
    else                   test_ans = 1'b0;
    reply  = dev_hit && ((test_en && test_ans) ||
                         ((read_en || write_en) && flags.ready));
    in_bus = (dev_hit && read_en && flags.ready) ? buf_q : '0;
  end

  a_r5_intr_inverted: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_hit && test_en && !read_en && !write_en && fn == FN_INT) |-> (reply != irq));

  a_r6_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_hit && read_en) |-> (in_bus == '0));

  a_r1_no_reply_unaddressed: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_hit |-> !reply);
endmodule

// File: rtl/pio_dev_ctrl.sv
module pio_dev_ctrl #(
  parameter int                         DATA_W    = 16,
  parameter logic [pio_pkg::DEV_W-1:0]  DEV_ID    = 6'o12,
  parameter logic [pio_pkg::ADDR_W-1:0] MASK_CODE = 10'o020,
  parameter int                         MASK_BIT  = 5,
  parameter pio_pkg::fn_t               FN_RDY    = 4'd0,
  parameter pio_pkg::fn_t               FN_BSY    = 4'd1,
  parameter pio_pkg::fn_t               FN_INT    = 4'd2,
  parameter pio_pkg::fn_t               FN_STOP   = 4'd3,
  parameter pio_pkg::fn_t               FN_GO_IN  = 4'd4,
  parameter pio_pkg::fn_t               FN_GO_OUT = 4'd5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [pio_pkg::ADDR_W-1:0] bus_addr,
  input  logic                       ctl_cmd,
  input  logic                       test_en,
  input  logic                       read_en,
  input  logic                       write_en,
  input  logic                       out_strobe,
  input  logic                       rdy_reset,
  input  logic                       mask_set,
  input  logic [DATA_W-1:0]          out_bus,
  input  logic                       mstr_clr,
  input  logic                       pwr_norm,
  input  logic [DATA_W-1:0]          dev_word_in,
  input  logic                       dev_word_arrived,
  input  logic                       dev_word_taken,
  output logic [DATA_W-1:0]          in_bus,
  output logic                       reply,
  output logic                       irq,
  output logic [DATA_W-1:0]          dev_word_out,
  output logic                       dev_busy,
  output logic                       dev_in_mode
);
  logic                dev_hit;
  logic                mask_hit;
  pio_pkg::fn_t        fn;
  pio_pkg::dev_flags_t flags;
  logic [DATA_W-1:0]   buf_q;
  logic                clr;

  assign clr = mstr_clr || pwr_norm;

  pio_addr_dec #(.DEV_ID(DEV_ID), .MASK_CODE(MASK_CODE)) u_dec (
    .addr(bus_addr), .dev_hit(dev_hit), .mask_hit(mask_hit), .fn(fn)
  );

  pio_dev_state #(
    .DATA_W(DATA_W), .MASK_BIT(MASK_BIT),
    .FN_STOP(FN_STOP), .FN_GO_IN(FN_GO_IN), .FN_GO_OUT(FN_GO_OUT)
  ) u_state (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .ocp_hit(ctl_cmd && dev_hit), .rrl_hit(rdy_reset && dev_hit),
    .otp_hit(out_strobe && dev_hit), .smk_hit(mask_set && mask_hit),
    .fn(fn), .out_bus(out_bus), .dev_word_in(dev_word_in),
    .dev_arrived(dev_word_arrived), .dev_taken(dev_word_taken),
    .flags(flags), .buf_q(buf_q)
  );

  pio_reply #(
    .DATA_W(DATA_W), .FN_RDY(FN_RDY), .FN_BSY(FN_BSY), .FN_INT(FN_INT)
  ) u_reply (
    .clk(clk), .rst_n(rst_n), .dev_hit(dev_hit), .fn(fn),
    .test_en(test_en), .read_en(read_en), .write_en(write_en),
    .flags(flags), .buf_q(buf_q),
    .reply(reply), .in_bus(in_bus), .irq(irq)
  );

  assign dev_word_out = buf_q;
  assign dev_busy     = flags.busy;
  assign dev_in_mode  = flags.dir_in;

  a_r3_stop_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && ctl_cmd && dev_hit && fn == FN_STOP) |=> (!dev_busy && $stable(irq)));

  a_r1_foreign_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !dev_hit && !dev_word_arrived && !dev_word_taken && !(mask_set && mask_hit))
      |=> ($stable(dev_word_out) && $stable(dev_busy) && $stable(dev_in_mode)));
endmodule

// File: tb/pio_dev_ctrl_bench.sv
module pio_dev_ctrl_bench;
  localparam logic [5:0] DEV   = 6'o12;
  localparam logic [5:0] OTHER = 6'o13;
  localparam int         MBIT  = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  bus_addr;
  logic        ctl_cmd, test_en, read_en, write_en, out_strobe, rdy_reset, mask_set;
  logic [15:0] out_bus, dev_word_in;
  logic        mstr_clr, pwr_norm, dev_word_arrived, dev_word_taken;
  logic [15:0] in_bus, dev_word_out;
  logic        reply, irq, dev_busy, dev_in_mode;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  bit          m_busy, m_ready, m_mask, m_dir_in;
  logic [15:0] m_buf;

  always #10 clk = ~clk;

  pio_dev_ctrl #(.DEV_ID(DEV), .MASK_CODE(10'o020), .MASK_BIT(MBIT)) u_pio_dev_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .ctl_cmd(ctl_cmd),
    .test_en(test_en), .read_en(read_en), .write_en(write_en),
    .out_strobe(out_strobe), .rdy_reset(rdy_reset), .mask_set(mask_set),
    .out_bus(out_bus), .mstr_clr(mstr_clr), .pwr_norm(pwr_norm),
    .dev_word_in(dev_word_in), .dev_word_arrived(dev_word_arrived),
    .dev_word_taken(dev_word_taken), .in_bus(in_bus), .reply(reply), .irq(irq),
    .dev_word_out(dev_word_out), .dev_busy(dev_busy), .dev_in_mode(dev_in_mode)
  );

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    bus_addr = '0; ctl_cmd = 0; test_en = 0; read_en = 0; write_en = 0;
    out_strobe = 0; rdy_reset = 0; mask_set = 0; out_bus = '0;
    mstr_clr = 0; pwr_norm = 0; dev_word_in = '0;
    dev_word_arrived = 0; dev_word_taken = 0;
  endtask

  task automatic model_edge();
    bit hit;
    logic [3:0] f;
    hit = (bus_addr[5:0] == DEV);
    f   = bus_addr[9:6];
    if (mstr_clr || pwr_norm) begin
      m_busy = 0; m_ready = 0; m_mask = 0;
    end else begin
      if (ctl_cmd && hit) begin
        if (f == 4'd3) m_busy = 0;
        else if (f == 4'd4) begin m_busy = 1; m_ready = 0; m_dir_in = 1; end
        else if (f == 4'd5) begin m_busy = 1; m_ready = 1; m_dir_in = 0; end
      end else if (rdy_reset && hit) begin
        m_ready = 0;
        if (m_dir_in) m_buf = '0;
      end else if (out_strobe && hit && m_ready) begin
        m_buf = out_bus;
      end else if (dev_word_arrived && m_busy && m_dir_in) begin
        m_buf = dev_word_in; m_ready = 1;
      end else if (dev_word_taken && m_busy && !m_dir_in) begin
        m_ready = 1;
      end
      if (mask_set && bus_addr == 10'o020) m_mask = out_bus[MBIT];
    end
  endtask

  // Compare all outputs with the model, then advance one clock.
  task automatic step(input string tag);
    bit hit;
    logic [3:0] f;
    bit e_reply;
    logic [15:0] e_bus;
    #2;
    hit = (bus_addr[5:0] == DEV);
    f   = bus_addr[9:6];
    e_reply = 0;
    if (hit && test_en) begin
      if (f == 4'd0) e_reply = m_ready;
      else if (f == 4'd1) e_reply = m_busy;
      else if (f == 4'd2) e_reply = !(m_ready && m_mask);
    end
    if (hit && (read_en || write_en) && m_ready) e_reply = 1;
    e_bus = (hit && read_en && m_ready) ? m_buf : 16'h0;
    chk(tag, "reply", {15'h0, reply}, {15'h0, e_reply});
    chk(tag, "in_bus", in_bus, e_bus);
    chk(tag, "irq", {15'h0, irq}, {15'h0, m_ready && m_mask});
    chk(tag, "dev_word_out", dev_word_out, m_buf);
    chk(tag, "dev_busy", {15'h0, dev_busy}, {15'h0, m_busy});
    chk(tag, "dev_in_mode", {15'h0, dev_in_mode}, {15'h0, m_dir_in});
    @(posedge clk);
    model_edge();
    @(negedge clk);
    idle();
  endtask

  task automatic cmd(input logic [3:0] f, input logic [5:0] d, input string tag);
    bus_addr = {f, d}; ctl_cmd = 1; step(tag);
  endtask

  task automatic test(input logic [3:0] f, input logic [5:0] d, input string tag);
    bus_addr = {f, d}; test_en = 1; step(tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    idle();
    rst_n = 0;
    m_busy = 0; m_ready = 0; m_mask = 0; m_dir_in = 0; m_buf = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    step("R12");                         // reset state
    test(4'd0, DEV, "R4");               // ready test, not ready
    test(4'd1, DEV, "R4");               // busy test, not busy
    test(4'd2, DEV, "R5");               // not interrupting -> reply

    cmd(4'd5, DEV, "R2");                // start output
    test(4'd0, DEV, "R4");
    test(4'd1, DEV, "R4");
    test(4'd7, DEV, "R4");               // undefined test function
    cmd(4'd3, OTHER, "R1");              // stop to another device
    test(4'd1, DEV, "R1");
    test(4'd1, OTHER, "R1");

    bus_addr = {4'd0, DEV}; write_en = 1; step("R13");
    bus_addr = {4'd0, DEV}; write_en = 1; out_strobe = 1; out_bus = 16'hA5C3; step("R8");
    bus_addr = {4'd0, OTHER}; out_strobe = 1; out_bus = 16'h1111; step("R1");
    bus_addr = {4'd0, DEV}; rdy_reset = 1; step("R7");   // output mode keeps buffer
    bus_addr = {4'd0, DEV}; write_en = 1; step("R13");   // not ready now
    bus_addr = {4'd0, DEV}; out_strobe = 1; out_bus = 16'h7777; step("R8"); // ignored, not ready
    dev_word_taken = 1; step("R8");
    test(4'd0, DEV, "R8");

    bus_addr = 10'o020; mask_set = 1; out_bus = 16'h0020; step("R10");
    step("R11");
    test(4'd2, DEV, "R5");               // interrupting -> no reply
    bus_addr = 10'o021; mask_set = 1; out_bus = 16'h0000; step("R10"); // wrong code
    step("R10");
    bus_addr = 10'o020; mask_set = 1; out_bus = 16'hFFDF; step("R10"); // bit 5 clear
    test(4'd2, DEV, "R5");
    bus_addr = 10'o020; mask_set = 1; out_bus = 16'h0020; step("R10");

    cmd(4'd3, DEV, "R3");                // stop: busy off, ready kept
    test(4'd0, DEV, "R3");
    step("R11");

    cmd(4'd4, DEV, "R2");                // start input
    bus_addr = {4'd0, DEV}; read_en = 1; step("R6");
    dev_word_in = 16'h3C5A; dev_word_arrived = 1; step("R9");
    bus_addr = {4'd0, DEV}; read_en = 1; step("R6");
    bus_addr = {4'd0, OTHER}; read_en = 1; step("R1");
    bus_addr = {4'd0, OTHER}; rdy_reset = 1; step("R1");
    bus_addr = {4'd0, DEV}; read_en = 1; rdy_reset = 1; step("R7");
    step("R7");
    dev_word_taken = 1; step("R9");      // wrong direction, no effect
    dev_word_in = 16'hBEEF; dev_word_arrived = 1; step("R9");
    step("R11");

    mstr_clr = 1; ctl_cmd = 1; bus_addr = {4'd5, DEV}; step("R12");
    step("R12");
    cmd(4'd5, DEV, "R2");
    bus_addr = 10'o020; mask_set = 1; out_bus = 16'h0020; step("R10");
    pwr_norm = 1; step("R12");
    step("R12");
    test(4'd1, DEV, "R12");

    done = 1'b1;
    finish_run();
  end
endmodule